// File: doc/BRIEF.md
# FIFO Flag-Offset Programming Controller

This block sets up the four threshold offsets that a pair of FIFOs uses for their almost-empty and almost-full flags. The slots are held in a fixed order: first FIFO almost-empty, first FIFO almost-full, second FIFO almost-empty, second FIFO almost-full (`ofs_y1`, `ofs_x1`, `ofs_y2`, `ofs_x2`). Each offset is 9 bits wide. The block runs entirely on the write-port clock. Three mode pins are captured while the master reset `mrst_n` is held low. The capture on the last clock edge before release picks one of three ways to fill the offsets:

- **Preset:** one fixed value goes into all four slots.
- **Parallel:** the first four writes on the write port are taken over as offset loads.
- **Serial:** a 36-bit stream is shifted in on a data pin, gated by an enable pin.

The block holds the write-ready flags low until the offsets are in place. It marks completion with a one-cycle `prog_done` pulse. Once programming is complete, writes pass through to the FIFO memory on `mem_wr`.

The control is a five-state machine. The states are:

- **ST_RST:** in reset, latching the mode pins.
- **ST_PAR:** capturing parallel writes.
- **ST_SER:** shifting serial bits.
- **ST_LOAD:** transferring the shifted word into the offsets.
- **ST_RUN:** normal operation.

The transitions are:

- **T_PRESET:** ST_RST to ST_RUN, in preset mode.
- **T_PAR:** ST_RST to ST_PAR, in parallel mode.
- **T_SER:** ST_RST to ST_SER, in serial mode.
- **T_PAR_DONE:** ST_PAR to ST_RUN, on the fourth captured write.
- **T_SER_LAST:** ST_SER to ST_LOAD, on the 36th shifted bit.
- **T_LOAD:** ST_LOAD to ST_RUN, unconditional.
- **T_MRST:** any state to ST_RST, while `mrst_n` is low.

Top module: `ofs_prog_ctrl`

## Requirements
- R1: At every clock edge with `mrst_n` low, the block enters reset. In reset all four offsets are 0, `wr_ready`, `fifo2_ready`, `prog_done` and `mem_wr` are 0, and `mem_wr` stays 0 even with `wr_en` high.
- R2: The mode is taken from `{prog_sel, fsel1_sen, fsel0_sd}` as sampled on the last clock edge with `mrst_n` low. Pin changes after release do not alter the chosen mode.
- R3: With `prog_sel`=1 and `{fsel1_sen,fsel0_sd}` nonzero, preset mode applies. Code 01 loads 8, code 10 loads 16 and code 11 loads 64 into all four offsets. After the first edge following release, both ready flags are high.
- R4: With `prog_sel`=1 and `{fsel1_sen,fsel0_sd}`=00, parallel mode applies. `wr_ready` is high from the first edge after release and `fifo2_ready` stays low. The first four edges with `wr_en` high load `wr_data` into `ofs_y1`, `ofs_x1`, `ofs_y2`, `ofs_x2` in that order. `mem_wr` stays 0 for those writes, and idle cycles between them are allowed.
- R5: In parallel mode, `fifo2_ready` rises after the edge of the fourth captured write. From then on, `wr_en` drives `mem_wr` and the offsets no longer change.
- R6: With `prog_sel`=0, serial mode applies. Each edge with `fsel1_sen` low shifts in `fsel0_sd`, and edges with `fsel1_sen` high keep the bits received so far. The 36 bits fill `ofs_y1` MSB first, then `ofs_x1`, `ofs_y2`, `ofs_x2`, ending with the LSB of `ofs_x2`.
- R7: In serial mode both ready flags stay low through the edge that takes the last bit. They go high on the following edge, and further serial activity has no effect on the offsets.
- R8: Offset values are stored without range checking; 0 and 511 are kept as given.
- R9: `prog_done` is high for exactly one cycle, coinciding with the first cycle in which `fifo2_ready` is high, in all three modes.
- R10: `mem_wr` is never high unless `wr_en` is high and programming is complete.

## Ports
| Port | Direction | Width | Description |
|------|-----------|-------|-------------|
| clk | input | 1 | Write-port clock |
| mrst_n | input | 1 | Master reset, active low, sampled on `clk` |
| prog_sel | input | 1 | Mode pin: 1 selects preset or parallel mode, 0 selects serial mode |
| fsel0_sd | input | 1 | Preset code bit 0 in reset; serial data afterwards |
| fsel1_sen | input | 1 | Preset code bit 1 in reset; serial enable afterwards (active low) |
| wr_en | input | 1 | Write request on the write port |
| wr_data | input | OFS_W | Offset field of the write data bus |
| wr_ready | output | 1 | First FIFO write-ready flag |
| fifo2_ready | output | 1 | Second FIFO write-ready flag |
| mem_wr | output | 1 | Write forwarded to FIFO memory |
| ofs_y1 | output | OFS_W | First FIFO almost-empty offset |
| ofs_x1 | output | OFS_W | First FIFO almost-full offset |
| ofs_y2 | output | OFS_W | Second FIFO almost-empty offset |
| ofs_x2 | output | OFS_W | Second FIFO almost-full offset |
| prog_done | output | 1 | One-cycle pulse when programming finishes |

## Verification
The assertions assume that `mrst_n` is driven low from time zero and held for at least one clock edge, so that the mode latch and the state register start from known values. They also assume that `wr_en` and the serial pins are valid on every edge. The bench changes all inputs only on falling edges and starts each scenario with a fresh reset of two cycles. It changes the mode pins to conflicting values just after release to show that they are not sampled again.

// File: rtl/ofs_pkg.sv
package ofs_pkg;

    typedef enum logic [2:0] {
        ST_RST,
        ST_PAR,
        ST_SER,
        ST_LOAD,
        ST_RUN
    } prog_state_t;

    typedef enum logic [1:0] {
        MD_PRESET,
        MD_PAR,
        MD_SER
    } prog_mode_t;

endpackage

// File: rtl/ofs_mode_dec.sv
module ofs_mode_dec
    import ofs_pkg::*;
#(
    parameter int OFS_W   = 9,
    parameter int PRE_LO  = 8,
    parameter int PRE_MID = 16,
    parameter int PRE_HI  = 64
) (
    input  logic             spm,
    input  logic             fs0,
    input  logic             fs1,
    output prog_mode_t       mode,
    output logic [OFS_W-1:0] preset
);

    always_comb begin
        preset = '0;
        if (!spm) begin
            mode = MD_SER;
        end else if (!fs0 && !fs1) begin
            mode = MD_PAR;
        end else begin
            mode = MD_PRESET;
            case ({fs1, fs0})
                2'b01:   preset = OFS_W'(PRE_LO);
                2'b10:   preset = OFS_W'(PRE_MID);
                default: preset = OFS_W'(PRE_HI);
            endcase
        end
    end

endmodule

// File: rtl/ofs_serial_rx.sv
module ofs_serial_rx #(
    parameter int TOTAL_W = 36,
    localparam int CNT_W  = $clog2(TOTAL_W + 1)
) (
    input  logic               clk,
    input  logic               clr,
    input  logic               shift_en,
    input  logic               sd_in,
    output logic [TOTAL_W-1:0] vec,
    output logic               last_bit
);

    logic [CNT_W-1:0] cnt;

    always_ff @(posedge clk) begin
        if (clr) begin
            vec <= '0;
            cnt <= '0;
        end else if (shift_en) begin
            vec <= {vec[TOTAL_W-2:0], sd_in};
            cnt <= cnt + 1'b1;
        end
    end

    assign last_bit = shift_en && (cnt == CNT_W'(TOTAL_W - 1));

endmodule

// File: rtl/ofs_bank.sv
module ofs_bank #(
    parameter int OFS_W   = 9,
    parameter int NREG    = 4,
    localparam int IDX_W  = $clog2(NREG),
    localparam int FLAT_W = NREG * OFS_W
) (
    input  logic              clk,
    input  logic              clr,
    input  logic              ld_all,
    input  logic [FLAT_W-1:0] all_val,
    input  logic              ld_one,
    input  logic [IDX_W-1:0]  idx,
    input  logic [OFS_W-1:0]  one_val,
    output logic [FLAT_W-1:0] ofs_flat
);

    for (genvar i = 0; i < NREG; i++) begin : g_reg
        localparam int LSB = (NREG - 1 - i) * OFS_W;
        logic [OFS_W-1:0] r;

        always_ff @(posedge clk) begin
            if (clr) begin
                r <= '0;
            end else if (ld_all) begin
                r <= all_val[LSB +: OFS_W];
            end else if (ld_one && idx == IDX_W'(i)) begin
                r <= one_val;
            end
        end

        assign ofs_flat[LSB +: OFS_W] = r;
    end

endmodule

// File: rtl/ofs_prog_ctrl.sv
module ofs_prog_ctrl
    import ofs_pkg::*;
#(
    parameter int OFS_W   = 9,
    parameter int PRE_LO  = 8,
    parameter int PRE_MID = 16,
    parameter int PRE_HI  = 64
) (
    input  logic             clk,
    input  logic             mrst_n,
    input  logic             prog_sel,
    input  logic             fsel0_sd,
    input  logic             fsel1_sen,
    input  logic             wr_en,
    input  logic [OFS_W-1:0] wr_data,
    output logic             wr_ready,
    output logic             fifo2_ready,
    output logic             mem_wr,
    output logic [OFS_W-1:0] ofs_y1,
    output logic [OFS_W-1:0] ofs_x1,
    output logic [OFS_W-1:0] ofs_y2,
    output logic [OFS_W-1:0] ofs_x2,
    output logic             prog_done
);

    localparam int NREG    = 4;
    localparam int IDX_W   = $clog2(NREG);
    localparam int SER_LEN = NREG * OFS_W;

    prog_state_t state, state_nx;
    prog_mode_t  mode;

    logic [2:0]         pins_q;
    logic [OFS_W-1:0]   preset;
    logic [IDX_W-1:0]   par_idx;
    logic               par_take;
    logic               ser_en;
    logic               ser_last;
    logic [SER_LEN-1:0] ser_vec;
    logic               ld_all;
    logic [SER_LEN-1:0] all_val;
    logic [SER_LEN-1:0] ofs_flat;
    logic               done_q;

    // Mode pins are followed while reset is low; the last capture wins.
    always_ff @(posedge clk) begin
        if (!mrst_n) begin
            pins_q <= {prog_sel, fsel1_sen, fsel0_sd};
        end
    end

    ofs_mode_dec #(
        .OFS_W  (OFS_W),
        .PRE_LO (PRE_LO),
        .PRE_MID(PRE_MID),
        .PRE_HI (PRE_HI)
    ) u_dec (
        .spm   (pins_q[2]),
        .fs0   (pins_q[0]),
        .fs1   (pins_q[1]),
        .mode  (mode),
        .preset(preset)
    );

    ofs_serial_rx #(
        .TOTAL_W(SER_LEN)
    ) u_ser (
        .clk     (clk),
        .clr     (!mrst_n),
        .shift_en(ser_en),
        .sd_in   (fsel0_sd),
        .vec     (ser_vec),
        .last_bit(ser_last)
    );

    ofs_bank #(
        .OFS_W(OFS_W),
        .NREG (NREG)
    ) u_bank (
        .clk     (clk),
        .clr     (!mrst_n),
        .ld_all  (ld_all),
        .all_val (all_val),
        .ld_one  (par_take),
        .idx     (par_idx),
        .one_val (wr_data),
        .ofs_flat(ofs_flat)
    );

    // State register
    always_ff @(posedge clk) begin
        if (!mrst_n) begin
            state   <= ST_RST;
            par_idx <= '0;
            done_q  <= 1'b0;
        end else begin
            state   <= state_nx;
            done_q  <= (state != ST_RUN) && (state_nx == ST_RUN);
            if (par_take) begin
                par_idx <= par_idx + 1'b1;
            end
        end
    end

    // Next-state logic
    always_comb begin
        state_nx = state;
        unique case (state)
            ST_RST: begin
                unique case (mode)
                    MD_PRESET: state_nx = ST_RUN;
                    MD_PAR:    state_nx = ST_PAR;
                    default:   state_nx = ST_SER;
                endcase
            end
            ST_PAR:  if (par_take && par_idx == IDX_W'(NREG - 1)) state_nx = ST_RUN;
            ST_SER:  if (ser_last) state_nx = ST_LOAD;
            ST_LOAD: state_nx = ST_RUN;
            ST_RUN:  state_nx = ST_RUN;
            default: state_nx = ST_RST;
        endcase
    end

    // Outputs
    always_comb begin
        wr_ready    = 1'b0;
        fifo2_ready = 1'b0;
        par_take    = 1'b0;
        ser_en      = 1'b0;
        ld_all      = 1'b0;
        all_val     = ser_vec;
        unique case (state)
            ST_RST: begin
                ld_all  = (mode == MD_PRESET);
                all_val = {NREG{preset}};
            end
            ST_PAR: begin
                wr_ready = 1'b1;
                par_take = wr_en;
            end
            ST_SER:  ser_en = !fsel1_sen;
            ST_LOAD: ld_all = 1'b1;
            ST_RUN: begin
                wr_ready    = 1'b1;
                fifo2_ready = 1'b1;
            end
            default: ;
        endcase
        mem_wr    = wr_en && (state == ST_RUN);
        prog_done = done_q;
    end

    assign ofs_y1 = ofs_flat[4*OFS_W-1 -: OFS_W];
    assign ofs_x1 = ofs_flat[3*OFS_W-1 -: OFS_W];
    assign ofs_y2 = ofs_flat[2*OFS_W-1 -: OFS_W];
    assign ofs_x2 = ofs_flat[OFS_W-1   -: OFS_W];

endmodule

// File: rtl/ofs_prog_chk.sv
module ofs_prog_chk #(
    parameter int OFS_W = 9
) (
    input logic             clk,
    input logic             mrst_n,
    input logic             wr_en,
    input logic             wr_ready,
    input logic             fifo2_ready,
    input logic             mem_wr,
    input logic             prog_done,
    input logic [OFS_W-1:0] ofs_y1,
    input logic [OFS_W-1:0] ofs_x1,
    input logic [OFS_W-1:0] ofs_y2,
    input logic [OFS_W-1:0] ofs_x2
);

    a_r1_reset_clears: assert property (@(posedge clk)
        !mrst_n |=> (!wr_ready && !fifo2_ready && !prog_done && !mem_wr
                     && ofs_y1 == '0 && ofs_x2 == '0));

    a_r9_done_single: assert property (@(posedge clk) disable iff (!mrst_n)
        prog_done |=> !prog_done);

    a_r9_done_with_ready: assert property (@(posedge clk) disable iff (!mrst_n)
        $rose(fifo2_ready) |-> prog_done);

    a_r7_ready_order: assert property (@(posedge clk) disable iff (!mrst_n)
        fifo2_ready |-> wr_ready);

    a_r10_mem_wr_gated: assert property (@(posedge clk) disable iff (!mrst_n)
        mem_wr |-> (wr_en && fifo2_ready));

    a_r5_offsets_frozen: assert property (@(posedge clk) disable iff (!mrst_n)
        (fifo2_ready && $past(fifo2_ready)) |-> $stable({ofs_y1, ofs_x1, ofs_y2, ofs_x2}));

endmodule

bind ofs_prog_ctrl ofs_prog_chk #(.OFS_W(OFS_W)) u_chk (
    .clk        (clk),
    .mrst_n     (mrst_n),
    .wr_en      (wr_en),
    .wr_ready   (wr_ready),
    .fifo2_ready(fifo2_ready),
    .mem_wr     (mem_wr),
    .prog_done  (prog_done),
    .ofs_y1     (ofs_y1),
    .ofs_x1     (ofs_x1),
    .ofs_y2     (ofs_y2),
    .ofs_x2     (ofs_x2)
);

// File: tb/sim_ofs_prog_ctrl.sv
`timescale 1ns/1ps
module sim_ofs_prog_ctrl;

    logic       clk = 1'b0;
    logic       mrst_n = 1'b0;
    logic       prog_sel = 1'b1;
    logic       fsel0_sd = 1'b1;
    logic       fsel1_sen = 1'b1;
    logic       wr_en = 1'b0;
    logic [8:0] wr_data = '0;
    logic       wr_ready, fifo2_ready, mem_wr, prog_done;
    logic [8:0] ofs_y1, ofs_x1, ofs_y2, ofs_x2;

    int  n_chk = 0;
    int  n_err = 0;
    bit  ended = 1'b0;

    always #2.5 clk = ~clk;

    ofs_prog_ctrl u0 (
        .clk(clk), .mrst_n(mrst_n), .prog_sel(prog_sel),
        .fsel0_sd(fsel0_sd), .fsel1_sen(fsel1_sen),
        .wr_en(wr_en), .wr_data(wr_data),
        .wr_ready(wr_ready), .fifo2_ready(fifo2_ready), .mem_wr(mem_wr),
        .ofs_y1(ofs_y1), .ofs_x1(ofs_x1), .ofs_y2(ofs_y2), .ofs_x2(ofs_x2),
        .prog_done(prog_done)
    );

    task automatic chk(input string req, input string what,
                       input logic [31:0] act, input logic [31:0] exp);
        n_chk++;
        if (act !== exp) begin
            n_err++;
            $display("FAIL %s %s: actual %0d expected %0d", req, what, act, exp);
        end
    endtask

    task automatic finish_run();
        if (!ended) begin
            ended = 1'b1;
            $display("Simulation finished: %0d checks, %0d errors", n_chk, n_err);
            $finish;
        end
    endtask

    task automatic tick();
        @(posedge clk);
        @(negedge clk);
    endtask

    task automatic chk_ofs(input string req, input logic [35:0] e);
        chk(req, "ofs_y1", ofs_y1, e[35:27]);
        chk(req, "ofs_x1", ofs_x1, e[26:18]);
        chk(req, "ofs_y2", ofs_y2, e[17:9]);
        chk(req, "ofs_x2", ofs_x2, e[8:0]);
    endtask

    // Reset with mode pins (s, f0, f1); after release drive (as, af0, af1).
    task automatic do_reset(input logic s, input logic f0, input logic f1,
                            input logic as, input logic af0, input logic af1);
        mrst_n = 1'b0; prog_sel = s; fsel0_sd = f0; fsel1_sen = f1; wr_en = 1'b1;
        tick();
        chk("R1", "wr_ready in reset", wr_ready, 0);
        chk("R1", "fifo2_ready in reset", fifo2_ready, 0);
        chk("R1", "mem_wr in reset", mem_wr, 0);
        chk("R1", "done in reset", prog_done, 0);
        chk_ofs("R1", 36'd0);
        wr_en = 1'b0;
        tick();
        mrst_n = 1'b1; prog_sel = as; fsel0_sd = af0; fsel1_sen = af1;
    endtask

    task automatic par_run(input string req, input logic [35:0] pv);
        logic [8:0] v;
        do_reset(1'b1, 1'b0, 1'b0, 1'b1, 1'b1, 1'b1);
        tick();
        chk("R4", "wr_ready after release", wr_ready, 1);
        chk("R4", "fifo2_ready low", fifo2_ready, 0);
        chk("R9", "done before writes", prog_done, 0);
        for (int k = 0; k < 4; k++) begin
            v = pv[(3-k)*9 +: 9];
            wr_en = 1'b1; wr_data = v;
            chk("R4", "stolen write not to memory", mem_wr, 0);
            tick();
            wr_en = 1'b0;
            if (k < 3) chk("R5", "fifo2_ready before 4th", fifo2_ready, 0);
            if (k == 1) tick();
        end
        chk_ofs(req, pv);
        chk("R5", "fifo2_ready after 4th", fifo2_ready, 1);
        chk("R9", "done pulse", prog_done, 1);
        wr_en = 1'b1; wr_data = 9'h0AA;
        chk("R5", "mem_wr in run", mem_wr, 1);
        tick();
        wr_en = 1'b0;
        chk("R9", "done cleared", prog_done, 0);
        chk_ofs("R5", pv);
    endtask

    task automatic ser_run(input string req, input logic [35:0] sv, input int pause_every);
        do_reset(1'b0, 1'b0, 1'b1, 1'b1, 1'b1, 1'b1);
        prog_sel = 1'b1;
        tick();
        chk("R7", "wr_ready low in serial", wr_ready, 0);
        wr_en = 1'b1;
        for (int b = 0; b < 36; b++) begin
            fsel0_sd = sv[35-b]; fsel1_sen = 1'b0;
            if (b == 20) chk("R10", "mem_wr during serial", mem_wr, 0);
            if (b == 35) chk("R7", "wr_ready before last", wr_ready, 0);
            tick();
            if (pause_every > 0 && b < 35 && (b % pause_every) == 0) begin
                fsel1_sen = 1'b1; fsel0_sd = ~sv[35-b];
                tick();
            end
        end
        fsel1_sen = 1'b1;
        chk("R7", "wr_ready right after last bit", wr_ready, 0);
        chk("R7", "fifo2_ready right after last bit", fifo2_ready, 0);
        wr_en = 1'b0;
        tick();
        chk("R7", "wr_ready after load", wr_ready, 1);
        chk("R7", "fifo2_ready after load", fifo2_ready, 1);
        chk("R9", "done pulse serial", prog_done, 1);
        chk_ofs(req, sv);
        fsel1_sen = 1'b0; fsel0_sd = 1'b1;
        repeat (3) tick();
        fsel1_sen = 1'b1;
        chk("R9", "done cleared serial", prog_done, 0);
        chk_ofs("R7", sv);
    endtask

    initial begin
        repeat (100000) @(posedge clk);
        n_chk++; n_err++;
        $display("FAIL watchdog: actual hung expected finished");
        finish_run();
    end

    initial begin
        logic [8:0] pre;
        @(negedge clk);
        // Preset sweep over all three codes
        for (int code = 1; code < 4; code++) begin
            pre = (code == 1) ? 9'd8 : (code == 2) ? 9'd16 : 9'd64;
            do_reset(1'b1, code[0], code[1], 1'b0, 1'b0, 1'b0);
            tick();
            chk_ofs("R3", {pre, pre, pre, pre});
            chk("R3", "wr_ready preset", wr_ready, 1);
            chk("R3", "fifo2_ready preset", fifo2_ready, 1);
            chk("R9", "done preset", prog_done, 1);
            tick();
            chk("R9", "done cleared preset", prog_done, 0);
        end
        // R2: last sampled pins before release decide the mode
        mrst_n = 1'b0; prog_sel = 1'b1; fsel0_sd = 1'b0; fsel1_sen = 1'b0;
        tick();
        fsel0_sd = 1'b1; fsel1_sen = 1'b1;
        tick();
        mrst_n = 1'b1; prog_sel = 1'b0; fsel0_sd = 1'b0; fsel1_sen = 1'b0;
        tick();
        chk_ofs("R2", {9'd64, 9'd64, 9'd64, 9'd64});
        chk("R2", "fifo2_ready with last capture", fifo2_ready, 1);
        // Parallel mode
        par_run("R4", {9'd5, 9'd1, 9'd508, 9'd300});
        par_run("R8", {9'd0, 9'd511, 9'd256, 9'd1});
        // Serial mode
        ser_run("R6", 36'h123456789, 0);
        ser_run("R6", 36'h9A5C3E0F1, 5);
        ser_run("R8", {9'd0, 9'd511, 9'd1, 9'd508}, 7);
        finish_run();
    end

endmodule